// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer and Vector Generator

This block sits between an interrupt priority resolver and the processor's acknowledge strobe. It counts the strobe pulses of one acknowledge sequence and, on each pulse, decides whether this device owns the data byte. When it does, it drives that byte. Two processor modes are supported. In the three-pulse mode the device returns a call opcode followed by a 16-bit service address. In the two-pulse mode the first pulse only freezes the priority decision, and the second pulse returns an 8-bit type byte.

Several such devices can be cascaded. A master places the 3-bit ID of the granted input on the cascade lines, but only when a slave is attached to that input. A slave compares the cascade lines with its programmed ID and drives the address bytes only on a match. The block also raises a one-cycle automatic end-of-interrupt strobe after the last pulse when that option is enabled. The strobe carries the frozen level, so the in-service logic knows which bit to clear.

All inputs are synchronous to `clk`. A pulse edge is detected by comparing the strobe with its value in the previous cycle.

Top module: `intack_vector_gen`

## Requirements
- R1: After reset, or after `init`, the pulse count is zero. `data_oe` is 0, `data_out` is 0, `cas_out` is 0 and `eoi_clr` is 0.
- R2: In three-pulse mode (`two_pulse`=0), during pulse 1 a master drives the opcode 8'hCD.
- R3: In three-pulse mode with `intv4`=1, byte 2 is {`addr_lo`[2:0], level[2:0], 2'b00}.
- R4: In three-pulse mode with `intv4`=0, byte 2 is {`addr_lo`[2:1], level[2:0], 3'b000}.
- R5: In three-pulse mode, byte 3 is `addr_hi`.
- R6: In two-pulse mode, pulse 1 drives nothing. Pulse 2 drives {`type_hi`[4:0], level[2:0]} for either value of `intv4`.
- R7: The level used in every byte, on the cascade lines and in `eoi_lvl` is `lvl_in` as sampled at the leading (falling) edge of pulse 1. Later changes of `lvl_in` have no effect until the next sequence.
- R8: A master drives the frozen level on `cas_out` from the trailing edge of pulse 1 until the trailing edge of the last pulse, and only if `slave_map`[level] is 1. Otherwise `cas_out` is 0. For an input that has a slave, the master does not drive the address bytes.
- R9: A slave (`is_master`=0) never drives pulse 1 of the three-pulse mode. It drives the address bytes only while `cas_in` equals `own_id`.
- R10: When `auto_eoi`=1, `eoi_clr` is high for exactly one cycle, in the cycle after the trailing edge of the last pulse (pulse 3, or pulse 2 in two-pulse mode), with `eoi_lvl` equal to the frozen level. When `auto_eoi`=0 it stays low.
- R11: `data_oe` is high only while `ack_n` is low and this device owns the byte. `data_out` is 0 whenever `data_oe` is 0.
- R12: `init` in the middle of a sequence returns the count to zero and releases the cascade lines. The next pulse is then treated as pulse 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Initialization pulse; clears the sequence |
| ack_n | input | 1 | Acknowledge strobe, active low |
| lvl_in | input | 3 | Granted level from the priority resolver |
| two_pulse | input | 1 | 1 = two-pulse type-byte mode, 0 = three-pulse call mode |
| intv4 | input | 1 | 1 = address interval 4, 0 = interval 8 |
| addr_lo | input | 3 | Programmed address bits 7..5 |
| addr_hi | input | 8 | Programmed address bits 15..8 |
| type_hi | input | 5 | Programmed type bits 7..3 |
| is_master | input | 1 | 1 = master, 0 = slave |
| slave_map | input | 8 | Bit i set means a slave is attached to input i |
| own_id | input | 3 | Slave ID |
| cas_in | input | 3 | Cascade lines as seen by a slave |
| auto_eoi | input | 1 | Enable the automatic end-of-interrupt strobe |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Data bus drive enable |
| cas_out | output | 3 | Cascade lines driven by a master |
| eoi_clr | output | 1 | One-cycle automatic end-of-interrupt strobe |
| eoi_lvl | output | 3 | Level to clear with `eoi_clr` |

## Verification
The checks assume that `two_pulse`, `intv4`, `is_master`, `slave_map` and `own_id` stay constant during a sequence. They also assume that each low or high phase of `ack_n` lasts at least one clock. The stimulus changes configuration only while the strobe is high and no sequence is open, with one exception: it applies `init` on purpose in the middle of a sequence. Each strobe phase is held for two clocks. `lvl_in` and `cas_in` are moved freely in the middle of a sequence, to exercise the freezing and the ID compare.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
    localparam int LVL_W   = 3;
    localparam int N_IN    = 1 << LVL_W;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2;
    localparam logic [BYTE_W-1:0] CALL_OP = 8'hCD;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ack;
        logic [LVL_W-1:0] lvl;
        logic             cas_on;
        logic             eoi;
    } seq_t;
endpackage

// File: rtl/ivg_pulse_ctr.sv
module ivg_pulse_ctr
    import ivg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             ack_n,
    input  logic             two_pulse,
    input  logic             auto_eoi,
    input  logic [LVL_W-1:0] lvl_in,
    output logic [CNT_W-1:0] idx,
    output logic [LVL_W-1:0] lvl_frz,
    output logic             cas_on,
    output logic             eoi
);
    seq_t q, d;
    logic lead, trail;
    logic [CNT_W-1:0] last;

    always_comb begin
        d     = q;
        d.eoi = 1'b0;
        d.ack = ack_n;
        lead  = q.ack & ~ack_n;
        trail = ~q.ack & ack_n;
        last  = two_pulse ? CNT_W'(1) : CNT_W'(2);
        if (init) begin
            d.cnt    = '0;
            d.cas_on = 1'b0;
        end else begin
            if (lead && q.cnt == '0) begin
                d.lvl = lvl_in;
            end
            if (trail) begin
                if (q.cnt >= last) begin
                    d.cnt    = '0;
                    d.cas_on = 1'b0;
                    d.eoi    = auto_eoi;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == '0) begin
                        d.cas_on = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, ack: 1'b1, lvl: '0, cas_on: 1'b0, eoi: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign idx     = q.cnt;
    assign lvl_frz = q.lvl;
    assign cas_on  = q.cas_on;
    assign eoi     = q.eoi;
endmodule

// File: rtl/ivg_byte_form.sv
module ivg_byte_form
    import ivg_pkg::*;
(
    input  logic              ack_n,
    input  logic [CNT_W-1:0]  idx,
    input  logic              two_pulse,
    input  logic              intv4,
    input  logic              is_master,
    input  logic [N_IN-1:0]   slave_map,
    input  logic [LVL_W-1:0]  own_id,
    input  logic [LVL_W-1:0]  cas_in,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [BYTE_W-1:0] addr_hi,
    input  logic [2:0]        addr_lo,
    input  logic [4:0]        type_hi,
    output logic [BYTE_W-1:0] data,
    output logic              oe
);
    logic [BYTE_W-1:0] vbyte;
    logic addr_mine, own;

    always_comb begin
        vbyte = '0;
        if (two_pulse) begin
            if (idx == CNT_W'(1)) vbyte = {type_hi, lvl};
        end else begin
            case (idx)
                CNT_W'(0): vbyte = CALL_OP;
                CNT_W'(1): vbyte = intv4 ? {addr_lo, lvl, 2'b00}
                                         : {addr_lo[2:1], lvl, 3'b000};
                CNT_W'(2): vbyte = addr_hi;
                default:   vbyte = '0;
            endcase
        end
        addr_mine = is_master ? ~slave_map[lvl] : (cas_in == own_id);
        if (two_pulse) begin
            own = (idx == CNT_W'(1)) && addr_mine;
        end else begin
            own = (idx == '0) ? is_master : addr_mine;
        end
        oe   = ~ack_n & own;
        data = oe ? vbyte : '0;
    end
endmodule

// File: rtl/ivg_cas_drive.sv
module ivg_cas_drive
    import ivg_pkg::*;
(
    input  logic             is_master,
    input  logic             cas_on,
    input  logic [N_IN-1:0]  slave_map,
    input  logic [LVL_W-1:0] lvl,
    output logic [LVL_W-1:0] cas_out
);
    always_comb begin
        cas_out = '0;
        if (is_master && cas_on && slave_map[lvl]) cas_out = lvl;
    end
endmodule

// File: rtl/intack_vector_gen.sv
module intack_vector_gen
    import ivg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              ack_n,
    input  logic [LVL_W-1:0]  lvl_in,
    input  logic              two_pulse,
    input  logic              intv4,
    input  logic [2:0]        addr_lo,
    input  logic [BYTE_W-1:0] addr_hi,
    input  logic [4:0]        type_hi,
    input  logic              is_master,
    input  logic [N_IN-1:0]   slave_map,
    input  logic [LVL_W-1:0]  own_id,
    input  logic [LVL_W-1:0]  cas_in,
    input  logic              auto_eoi,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic [LVL_W-1:0]  cas_out,
    output logic              eoi_clr,
    output logic [LVL_W-1:0]  eoi_lvl
);
    logic [CNT_W-1:0] idx;
    logic [LVL_W-1:0] lvl_frz;
    logic             cas_on;

    ivg_pulse_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .init(init), .ack_n(ack_n),
        .two_pulse(two_pulse), .auto_eoi(auto_eoi), .lvl_in(lvl_in),
        .idx(idx), .lvl_frz(lvl_frz), .cas_on(cas_on), .eoi(eoi_clr)
    );

    ivg_byte_form u_byte (
        .ack_n(ack_n), .idx(idx), .two_pulse(two_pulse), .intv4(intv4),
        .is_master(is_master), .slave_map(slave_map), .own_id(own_id),
        .cas_in(cas_in), .lvl(lvl_frz), .addr_hi(addr_hi), .addr_lo(addr_lo),
        .type_hi(type_hi), .data(data_out), .oe(data_oe)
    );

    ivg_cas_drive u_cas (
        .is_master(is_master), .cas_on(cas_on), .slave_map(slave_map),
        .lvl(lvl_frz), .cas_out(cas_out)
    );

    assign eoi_lvl = lvl_frz;
endmodule

// File: rtl/ivg_checker.sv
module ivg_checker
    import ivg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              init,
    input logic              ack_n,
    input logic              two_pulse,
    input logic              is_master,
    input logic [CNT_W-1:0]  idx,
    input logic [BYTE_W-1:0] data_out,
    input logic              data_oe,
    input logic [LVL_W-1:0]  cas_out,
    input logic              eoi_clr
);
    assert_oe_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ack_n);
    assert_data_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> data_out == '0);
    assert_cas_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_out != '0) |-> is_master);
    assert_eoi_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_clr |=> !eoi_clr);
    assert_two_first_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (two_pulse && idx == '0) |-> !data_oe);
    assert_slave_no_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !two_pulse && idx == '0) |-> !data_oe);
    assert_init_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (idx == '0 && cas_out == '0));
endmodule

bind intack_vector_gen ivg_checker u_chk (.*);

// File: tb/intack_vector_gen_bench.sv
module intack_vector_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init = 1'b0, ack_n = 1'b1;
    logic [2:0] lvl_in = '0, addr_lo = '0, own_id = '0, cas_in = '0;
    logic       two_pulse = 1'b0, intv4 = 1'b1, is_master = 1'b1, auto_eoi = 1'b0;
    logic [7:0] addr_hi = '0, slave_map = '0;
    logic [4:0] type_hi = '0;
    logic [7:0] data_out;
    logic       data_oe, eoi_clr;
    logic [2:0] cas_out, eoi_lvl;

    int checks = 0, failures = 0;
    string tag = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    intack_vector_gen u_intack_vector_gen (
        .clk(clk), .rst_n(rst_n), .init(init), .ack_n(ack_n), .lvl_in(lvl_in),
        .two_pulse(two_pulse), .intv4(intv4), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .type_hi(type_hi), .is_master(is_master), .slave_map(slave_map),
        .own_id(own_id), .cas_in(cas_in), .auto_eoi(auto_eoi),
        .data_out(data_out), .data_oe(data_oe), .cas_out(cas_out),
        .eoi_clr(eoi_clr), .eoi_lvl(eoi_lvl)
    );

    // behavioural reference state
    int m_pulses = 0;
    int m_lvl = 0;
    bit m_cas = 0, m_prev = 1, m_eoi = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pulses = 0; m_lvl = 0; m_cas = 0; m_prev = 1; m_eoi = 0;
        end else begin
            int limit;
            limit = two_pulse ? 1 : 2;
            m_eoi = 0;
            if (init) begin
                m_pulses = 0; m_cas = 0;
            end else begin
                if (m_prev && !ack_n && m_pulses == 0) m_lvl = lvl_in;
                if (!m_prev && ack_n) begin
                    if (m_pulses >= limit) begin
                        m_pulses = 0; m_cas = 0; m_eoi = auto_eoi;
                    end else begin
                        if (m_pulses == 0) m_cas = 1;
                        m_pulses++;
                    end
                end
            end
            m_prev = ack_n;
        end
    end

    task automatic cmp(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int byte_v, own, oe_e, data_e, cas_e;
        bit mine;
        mine = is_master ? !slave_map[m_lvl] : (cas_in == own_id);
        byte_v = 0; own = 0;
        if (two_pulse) begin
            if (m_pulses == 1) begin byte_v = type_hi * 8 + m_lvl; own = mine; end
        end else if (m_pulses == 0) begin
            byte_v = 205; own = is_master;
        end else if (m_pulses == 1) begin
            byte_v = intv4 ? addr_lo * 32 + m_lvl * 4 : (addr_lo / 2) * 64 + m_lvl * 8;
            own = mine;
        end else begin
            byte_v = addr_hi; own = mine;
        end
        oe_e   = (!ack_n && own) ? 1 : 0;
        data_e = oe_e ? byte_v : 0;
        cas_e  = (is_master && m_cas && slave_map[m_lvl]) ? m_lvl : 0;
        cmp(data_oe, oe_e, "data_oe");
        cmp(data_out, data_e, "data_out");
        cmp(cas_out, cas_e, "cas_out");
        cmp(eoi_clr, m_eoi, "eoi_clr");
        if (m_eoi) cmp(eoi_lvl, m_lvl, "eoi_lvl");
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse();
        ack_n = 1'b0; step(2);
        ack_n = 1'b1; step(2);
    endtask

    task automatic seq(input int n);
        for (int i = 0; i < n; i++) pulse();
        step(2);
    endtask

    initial begin
        // R1: reset state
        step(3);
        rst_n = 1'b1;
        step(2);
        cmp(data_oe, 0, "reset data_oe");
        cmp(cas_out, 0, "reset cas_out");
        tag = "R2 R3 R5 R11";
        addr_lo = 3'b101; addr_hi = 8'hA7; lvl_in = 3'd5; intv4 = 1'b1;
        seq(3);
        tag = "R2 R4 R5";
        intv4 = 1'b0; lvl_in = 3'd6; addr_lo = 3'b011; addr_hi = 8'h3C;
        seq(3);
        tag = "R6";
        two_pulse = 1'b1; type_hi = 5'h15; lvl_in = 3'd3;
        seq(2);
        intv4 = 1'b1; lvl_in = 3'd7;
        seq(2);
        tag = "R7";
        two_pulse = 1'b0; lvl_in = 3'd2;
        ack_n = 1'b0; step(1); lvl_in = 3'd6; step(1); ack_n = 1'b1; step(2);
        lvl_in = 3'd1; pulse(); lvl_in = 3'd4; pulse(); step(2);
        tag = "R8";
        slave_map = 8'b0001_0100; lvl_in = 3'd2;
        seq(3);
        lvl_in = 3'd4; two_pulse = 1'b1;
        seq(2);
        lvl_in = 3'd0; two_pulse = 1'b0;
        seq(3);
        tag = "R9";
        is_master = 1'b0; own_id = 3'd4; cas_in = 3'd4; lvl_in = 3'd5;
        seq(3);
        cas_in = 3'd2;
        seq(3);
        two_pulse = 1'b1; cas_in = 3'd4;
        ack_n = 1'b0; step(2); ack_n = 1'b1; step(2);
        ack_n = 1'b0; step(1); cas_in = 3'd1; step(1); ack_n = 1'b1; step(4);
        tag = "R10";
        is_master = 1'b1; slave_map = '0; auto_eoi = 1'b1; lvl_in = 3'd6;
        seq(2);
        two_pulse = 1'b0; lvl_in = 3'd3;
        seq(3);
        auto_eoi = 1'b0;
        seq(3);
        tag = "R12";
        auto_eoi = 1'b1; slave_map = 8'hFF; lvl_in = 3'd5;
        pulse();
        init = 1'b1; step(1); init = 1'b0; step(1);
        cmp(cas_out, 0, "cas after init");
        lvl_in = 3'd1;
        seq(3);
        tag = "R11";
        step(6);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog %s actual=hung expected=finished", tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule